// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block sits between two shared 18-bit data buses and carries words in either direction. Each direction owns one storage element and four controls: an active-low drive enable, a latch enable, a capture strobe and an active-low strobe enable. Each direction can pass the source bus straight through, freeze the last word it saw, or take a snapshot when its strobe rises. Its result goes out on the opposite bus through non-inverting three-state drivers.

All state is clocked by one core clock. The capture strobes are ordinary inputs that this clock samples, so a strobe edge is recognised at the first clock edge where the strobe reads high after reading low. A synchronous active-low reset stands in for power-up: it clears both stored words and holds both drivers off. Each source bus has a keeper. While the block itself drives a bus, the path that reads that bus sees the last level an outside agent put on it, and never its own echo.

Top module: `ubt_transceiver`

## Requirements
- R1: While `rst_n` is low, neither bus is driven, whatever the enables say. After release, both stored words are zero, so a direction whose latch enable is low and whose drive enable is low outputs all zeros until its first capture.
- R2: While `ab_le` is high and `ab_oe_n` is low, `b_bus` carries the current `a_bus` word bit for bit, in the same cycle.
- R3: While `ab_le` is low and no rising strobe is accepted, the A-to-B stored word and the driven `b_bus` value do not change, however `a_bus` moves.
- R4: When `ab_cp` reads low at one clock edge and high at the next, and `ab_le` and `ab_ce_n` are both low at that second edge, the A-to-B path stores the `a_bus` word sampled at that edge. The stored word appears on `b_bus` from that edge on.
- R5: While `ab_ce_n` is high, rising edges of `ab_cp` have no effect on the stored word.
- R6: When `ab_le` falls, the A-to-B path keeps the word it sampled at the last clock edge where `ab_le` was high.
- R7: While `ab_oe_n` is high, `b_bus` is released to high impedance. While `ba_oe_n` is high, `a_bus` is released. Another agent's word on the bus then reads back unchanged.
- R8: The B-to-A path obeys the rules above using `ba_oe_n`, `ba_le`, `ba_cp` and `ba_ce_n`, with `b_bus` as its source and `a_bus` as its destination.
- R9: While `ba_oe_n` is low, the A-to-B path reads the `a_bus` level held from the last clock edge where `ba_oe_n` was high, not the word the block itself is driving. The same holds for the B-to-A path while `ab_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; samples strobes and updates all state |
| rst_n | input | 1 | Synchronous active-low reset (power-up stand-in) |
| a_bus | inout | 18 | A-side bus: source of A-to-B, destination of B-to-A |
| b_bus | inout | 18 | B-side bus: source of B-to-A, destination of A-to-B |
| ab_oe_n | input | 1 | Drive enable for b_bus, active low |
| ab_le | input | 1 | A-to-B latch enable, high = pass-through |
| ab_cp | input | 1 | A-to-B capture strobe, rising edge captures |
| ab_ce_n | input | 1 | A-to-B strobe enable, active low |
| ba_oe_n | input | 1 | Drive enable for a_bus, active low |
| ba_le | input | 1 | B-to-A latch enable, high = pass-through |
| ba_cp | input | 1 | B-to-A capture strobe, rising edge captures |
| ba_ce_n | input | 1 | B-to-A strobe enable, active low |

## Verification
On every cycle, the assertions check that reset keeps both drivers off and that pass-through mode forwards the source bus unchanged. They also check that a stored word stays fixed when no enabled rising edge occurred, that a qualified edge loads the sampled word, and that the keeper freezes while the block owns its bus. The bench's scenarios are needed for behaviours that span cycles or involve the far side: the word kept when the latch closes, the release of each bus to another driver, and the keeper's held word reaching the opposite bus several cycles later. They also cover the two directions interleaving under random control.

// File: rtl/ubt_pkg.sv
// Package ubt_pkg
// Shared types for the bidirectional transceiver: default word width and the
// per-direction storage mode. Assumes one core clock drives all state.
package ubt_pkg;

    localparam int UBT_DEFAULT_W = 18;

    // Storage behaviour of one direction in the current cycle
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_PASS    = 2'd1,
        MODE_CAPTURE = 2'd2
    } path_mode_e;

    // Latch enable wins over an accepted strobe edge; otherwise hold
    function automatic path_mode_e pick_mode(input logic le, input logic fire);
        if (le)
            return MODE_PASS;
        else if (fire)
            return MODE_CAPTURE;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/ubt_edge_detect.sv
// Module ubt_edge_detect
// Finds a rising edge of a capture strobe sampled by the core clock and
// qualifies it with an active-low strobe enable. Assumes the strobe is slow
// against the core clock (high and low each for at least one clock period).
// The previous-sample register resets to one, so a strobe that is already
// high at reset release does not count as an edge.
module ubt_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic strobe_en_n,
    output logic fire
);

    logic strobe_prev_q;

    // Remember the strobe level of the previous clock edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_prev_q <= 1'b1;
        else
            strobe_prev_q <= strobe;
    end

    // Accepted edge: low before, high now, enable asserted
    always_comb begin
        fire = strobe && !strobe_prev_q && !strobe_en_n;
    end

endmodule

// File: rtl/ubt_bus_keeper.sv
// Module ubt_bus_keeper
// Bus-hold stand-in for one source bus. While another agent owns the bus, the
// keeper follows it and the path reads the bus directly. While this block
// drives the bus itself, the keeper freezes and the path reads the frozen word.
// Assumes self_drive is already gated by reset.
module ubt_bus_keeper #(
    parameter int W = ubt_pkg::UBT_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_in,
    input  logic         self_drive,
    output logic [W-1:0] eff_word,
    output logic [W-1:0] held_word
);

    logic [W-1:0] held_q;

    // Track the externally owned bus level; freeze while driving it ourselves
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (!self_drive)
            held_q <= bus_in;
    end

    // Word seen by the storage path this cycle
    always_comb begin
        eff_word  = self_drive ? held_q : bus_in;
        held_word = held_q;
    end

endmodule

// File: rtl/ubt_store_cell.sv
// Module ubt_store_cell
// One direction's storage element: a transparent latch and an edge register
// merged into a single clocked word. In pass mode the output follows the
// input at once and the word tracks it every clock, so closing the latch
// leaves the last sampled word. Assumes mode comes from pick_mode.
module ubt_store_cell #(
    parameter int W = ubt_pkg::UBT_DEFAULT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ubt_pkg::path_mode_e mode,
    input  logic [W-1:0]       din,
    output logic [W-1:0]       word_q,
    output logic [W-1:0]       dout
);

    import ubt_pkg::*;

    logic [W-1:0] store_q;

    // Load on pass or capture, keep otherwise; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            case (mode)
                MODE_PASS:    store_q <= din;
                MODE_CAPTURE: store_q <= din;
                default:      store_q <= store_q;
            endcase
        end
    end

    // Output: live input while transparent, stored word otherwise
    always_comb begin
        word_q = store_q;
        dout   = (mode == MODE_PASS) ? din : store_q;
    end

endmodule

// File: rtl/ubt_dir_path.sv
// Module ubt_dir_path
// Complete data path of one direction: keeper on the source bus, strobe edge
// detector, mode selection and storage cell. The three-state driver stays in
// the top module, next to the bus nets. Assumes src_self_drive is high while
// this block drives the source bus from the opposite direction.
module ubt_dir_path #(
    parameter int W = ubt_pkg::UBT_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_bus,
    input  logic         src_self_drive,
    input  logic         le,
    input  logic         cp,
    input  logic         ce_n,
    output logic [W-1:0] out_word,
    output logic [W-1:0] store_word,
    output logic [W-1:0] keep_word
);

    import ubt_pkg::*;

    logic [W-1:0] eff_word;
    logic         fire;
    path_mode_e   mode;

    ubt_bus_keeper #(.W(W)) u_keeper (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_in     (src_bus),
        .self_drive (src_self_drive),
        .eff_word   (eff_word),
        .held_word  (keep_word)
    );

    ubt_edge_detect u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (cp),
        .strobe_en_n (ce_n),
        .fire        (fire)
    );

    // Choose this cycle's storage behaviour
    always_comb begin
        mode = pick_mode(le, fire);
    end

    ubt_store_cell #(.W(W)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .din    (eff_word),
        .word_q (store_word),
        .dout   (out_word)
    );

endmodule

// File: rtl/ubt_transceiver.sv
// Module ubt_transceiver
// Two-way registered bus transceiver. Index 0 is A-to-B, index 1 is B-to-A.
// Each direction reads one bus and drives the other through a three-state
// driver, enabled active low and forced off during reset. Assumes the
// surrounding system never enables both drivers at once.
module ubt_transceiver #(
    parameter int W = ubt_pkg::UBT_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    inout  wire  [W-1:0] a_bus,
    inout  wire  [W-1:0] b_bus,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_cp,
    input  logic         ab_ce_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_cp,
    input  logic         ba_ce_n
);

    localparam int NDIR = 2;

    logic [W-1:0] src_word   [NDIR];
    logic [W-1:0] out_word   [NDIR];
    logic [W-1:0] store_word [NDIR];
    logic [W-1:0] keep_word  [NDIR];
    logic [NDIR-1:0] le_v, cp_v, ce_n_v, oe_n_v, drive;

    // Gather per-direction controls and source buses into indexed form
    always_comb begin
        src_word[0] = a_bus;
        src_word[1] = b_bus;
        le_v   = {ba_le,   ab_le};
        cp_v   = {ba_cp,   ab_cp};
        ce_n_v = {ba_ce_n, ab_ce_n};
        oe_n_v = {ba_oe_n, ab_oe_n};
    end

    // Drivers are on only out of reset and with the enable asserted
    always_comb begin
        drive = {NDIR{rst_n}} & ~oe_n_v;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        ubt_dir_path #(.W(W)) u_path (
            .clk            (clk),
            .rst_n          (rst_n),
            .src_bus        (src_word[d]),
            .src_self_drive (drive[NDIR-1-d]),
            .le             (le_v[d]),
            .cp             (cp_v[d]),
            .ce_n           (ce_n_v[d]),
            .out_word       (out_word[d]),
            .store_word     (store_word[d]),
            .keep_word      (keep_word[d])
        );
    end

    // Non-inverting three-state drivers onto the destination buses
    assign b_bus = drive[0] ? out_word[0] : {W{1'bz}};
    assign a_bus = drive[1] ? out_word[1] : {W{1'bz}};

endmodule

// File: rtl/ubt_transceiver_chk.sv
// Module ubt_transceiver_chk
// Property checker bound into ubt_transceiver. Observes the buses, the
// controls and the stored and kept words of both directions. Assumes strobes
// are sampled by clk in the same way as the design.
module ubt_transceiver_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_bus,
    input logic [W-1:0] b_bus,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_cp,
    input logic         ab_ce_n,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_cp,
    input logic         ba_ce_n,
    input logic [1:0]   drive,
    input logic [W-1:0] ab_store,
    input logic [W-1:0] ba_store,
    input logic [W-1:0] a_keep,
    input logic [W-1:0] b_keep
);

    // R1
    always @(posedge clk) begin
        if (rst_n === 1'b0)
            reset_release_chk: assert (drive == 2'b00);
    end

    // R2
    ab_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_le && !ab_oe_n && ba_oe_n) |-> (b_bus == a_bus));

    // R8
    ba_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_le && !ba_oe_n && ab_oe_n) |-> (a_bus == b_bus));

    // R3
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && !$past(ab_le) && ($past(ab_cp) == $past(ab_cp, 2)))
        |-> $stable(ab_store));

    // R8
    ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && !$past(ba_le) && ($past(ba_cp) == $past(ba_cp, 2)))
        |-> $stable(ba_store));

    // R4
    ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(ab_cp) && !$past(ab_cp, 2) && !$past(ab_le)
         && !$past(ab_ce_n) && $past(ba_oe_n))
        |-> (ab_store == $past(a_bus)));

    // R5
    ab_ce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ab_le) && $past(ab_ce_n)) |-> $stable(ab_store));

    // R9
    a_keeper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ba_oe_n)) |-> $stable(a_keep));

    // R9
    b_keeper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ab_oe_n)) |-> $stable(b_keep));

    // usage rule: the two drivers are never enabled together
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ab_oe_n && !ba_oe_n));

endmodule

bind ubt_transceiver ubt_transceiver_chk #(.W(W)) u_ubt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_bus    (a_bus),
    .b_bus    (b_bus),
    .ab_oe_n  (ab_oe_n),
    .ab_le    (ab_le),
    .ab_cp    (ab_cp),
    .ab_ce_n  (ab_ce_n),
    .ba_oe_n  (ba_oe_n),
    .ba_le    (ba_le),
    .ba_cp    (ba_cp),
    .ba_ce_n  (ba_ce_n),
    .drive    (drive),
    .ab_store (store_word[0]),
    .ba_store (store_word[1]),
    .a_keep   (keep_word[0]),
    .b_keep   (keep_word[1])
);

// File: tb/test_ubt_transceiver.sv
`timescale 1ns/1ps
// Bench for ubt_transceiver: directed corner cases followed by seeded random
// control and data, checked against a bench-side model built from the brief.
module test_ubt_transceiver;

    localparam int W = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_val = '0, b_val = '0;
    logic a_tb_en = 1'b0, b_tb_en = 1'b0;
    logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_cp = 1'b0, ab_ce_n = 1'b1;
    logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_cp = 1'b0, ba_ce_n = 1'b1;
    wire  [W-1:0] a_bus, b_bus;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model state, index 0 = A-to-B, 1 = B-to-A
    logic [W-1:0] m_st [2];
    logic         m_prev [2];
    logic [W-1:0] m_keep [2];

    always #10 clk = ~clk;

    assign a_bus = a_tb_en ? a_val : {W{1'bz}};
    assign b_bus = b_tb_en ? b_val : {W{1'bz}};

    ubt_transceiver #(.W(W)) i_ubt_transceiver (
        .clk(clk), .rst_n(rst_n), .a_bus(a_bus), .b_bus(b_bus),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_cp(ab_cp), .ab_ce_n(ab_ce_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cp(ba_cp), .ba_ce_n(ba_ce_n)
    );

    function automatic logic [W-1:0] f_out(input logic le, input logic [W-1:0] eff,
                                           input logic [W-1:0] st);
        return le ? eff : st;
    endfunction

    function automatic logic [W-1:0] f_next(input logic le, input logic cp, input logic prev,
                                            input logic ce_n, input logic [W-1:0] eff,
                                            input logic [W-1:0] st);
        if (le) return eff;
        if (cp && !prev && !ce_n) return eff;
        return st;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check mid-cycle, update the model at posedge
    task automatic cyc(input logic aoe, input logic ale, input logic acp, input logic ace,
                       input logic boe, input logic ble, input logic bcp, input logic bce,
                       input logic [W-1:0] av, input logic [W-1:0] bv, input string tag);
        logic [W-1:0] eff_a, eff_b, n0, n1;
        @(negedge clk);
        ab_oe_n = aoe; ab_le = ale; ab_cp = acp; ab_ce_n = ace;
        ba_oe_n = boe; ba_le = ble; ba_cp = bcp; ba_ce_n = bce;
        a_val = av; b_val = bv;
        a_tb_en = boe; b_tb_en = aoe;
        #2;
        eff_a = boe ? av : m_keep[0];
        eff_b = aoe ? bv : m_keep[1];
        if (!aoe) check((tag != "") ? tag : (ale ? "R2" : "R3"), b_bus, f_out(ale, eff_a, m_st[0]));
        else      check("R7 b_bus released", b_bus, bv);
        if (!boe) check("R8", a_bus, f_out(ble, eff_b, m_st[1]));
        else      check("R7 a_bus released", a_bus, av);
        @(posedge clk);
        n0 = f_next(ale, acp, m_prev[0], ace, eff_a, m_st[0]);
        n1 = f_next(ble, bcp, m_prev[1], bce, eff_b, m_st[1]);
        m_st[0] = n0; m_st[1] = n1;
        m_prev[0] = acp; m_prev[1] = bcp;
        if (boe) m_keep[0] = av;
        if (aoe) m_keep[1] = bv;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic aoe, boe;
        seed = $urandom(32'd7411);
        m_st[0] = '0; m_st[1] = '0; m_prev[0] = 1'b1; m_prev[1] = 1'b1;
        m_keep[0] = '0; m_keep[1] = '0;

        // R1: in reset, enables asserted, block must not drive
        @(negedge clk);
        ab_oe_n = 1'b0; ba_oe_n = 1'b0; ab_le = 1'b1; ba_le = 1'b1;
        a_val = 18'h2A5A5; b_val = 18'h15A5A; a_tb_en = 1'b1; b_tb_en = 1'b1;
        repeat (3) begin
            @(negedge clk); #2;
            check("R1 a_bus during reset", a_bus, 18'h2A5A5);
            check("R1 b_bus during reset", b_bus, 18'h15A5A);
        end
        @(negedge clk);
        rst_n = 1'b1; ab_oe_n = 1'b1; ba_oe_n = 1'b1; ab_le = 1'b0; ba_le = 1'b0;
        @(posedge clk);
        m_keep[0] = 18'h2A5A5; m_keep[1] = 18'h15A5A;
        // R1: stored words cleared
        cyc(0,0,0,1, 1,0,0,1, 18'h3FFFF, 18'h0, "R1 cleared AB word");
        cyc(1,0,0,1, 0,0,0,1, 18'h0, 18'h3FFFF, "");

        // R2 then R6: pass-through, then close latch and change input
        cyc(0,1,0,1, 1,0,0,1, 18'h12345, 18'h0, "R2");
        cyc(0,0,0,1, 1,0,0,1, 18'h0ABCD, 18'h0, "R6 latch closed");
        cyc(0,0,0,1, 1,0,0,1, 18'h3C3C3, 18'h0, "R6 latch closed");

        // R4: enabled rising edge, then R3 hold with strobe steady high and low
        cyc(0,0,0,0, 1,0,0,1, 18'h11111, 18'h0, "R3");
        cyc(0,0,1,0, 1,0,0,1, 18'h2BEEF, 18'h0, "R3");
        cyc(0,0,1,0, 1,0,0,1, 18'h00F0F, 18'h0, "R4 captured");
        cyc(0,0,1,0, 1,0,0,1, 18'h3F00F, 18'h0, "R3 strobe high");
        cyc(0,0,0,0, 1,0,0,1, 18'h01010, 18'h0, "R3 strobe low");

        // R5: strobe edge with enable negated
        cyc(0,0,1,1, 1,0,0,1, 18'h35555, 18'h0, "R3");
        cyc(0,0,0,1, 1,0,0,1, 18'h0AAAA, 18'h0, "R5 edge ignored");
        cyc(0,0,1,1, 1,0,0,1, 18'h1CAFE, 18'h0, "R5 edge ignored");
        cyc(0,0,1,1, 1,0,0,1, 18'h1CAFE, 18'h0, "R5 edge ignored");

        // R8: B-to-A capture
        cyc(1,0,0,1, 0,0,0,0, 18'h0, 18'h2468A, "");
        cyc(1,0,0,1, 0,0,1,0, 18'h0, 18'h13579, "");
        cyc(1,0,0,1, 0,0,1,0, 18'h0, 18'h00001, "");

        // R9: keeper holds A level while the block drives a_bus
        cyc(1,0,0,1, 1,0,0,1, 18'h2D2D2, 18'h0, "");
        cyc(1,1,0,1, 0,0,0,1, 18'h0, 18'h0, "");
        cyc(0,0,0,1, 1,0,0,1, 18'h11111, 18'h0, "R9 kept level");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            aoe = 1'b1; boe = 1'b1;
            case ($urandom % 3)
                0: aoe = 1'b0;
                1: boe = 1'b0;
                default: ;
            endcase
            cyc(aoe, ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
                boe, ($urandom % 4) == 0, 1'($urandom), 1'($urandom),
                W'($urandom), W'($urandom), "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule